// File: doc/BRIEF.md
# Watermark DMA Request and Burst Sizer

This block sits between a block-oriented card data buffer and an internal bus-master DMA engine. It decides when the engine should be asked to move data, and how many 32-bit words the next burst carries. The decision uses the buffer occupancy (read) or free space (write), a configured watermark in words, and the words still left in the current block.

Software arms a transfer with a block size in bytes and a block count. Each burst is the configured watermark, or fewer words when the current block has fewer words left. After the short final burst of a block, the size goes back to the watermark for the next block. A block size that is not a multiple of four ends in a word that is only partly valid. A stuff-byte mask tells the card side which byte lanes of that word to discard. When internal DMA is disabled, the same threshold drives a request line for an external DMA controller instead. After the last word of the last block, a one-cycle completion flag is raised and the block stays quiet until it is armed again.

Top module: `wm_burst_sizer`

## Requirements
- R1: While reset is held, dmaReq, extReq, xferDone, burstLen and stuffMask are all zero.
- R2: When armed, with dmaEn high and no burst in progress, dmaReq rises on the clock edge after bufLevel first meets the active threshold. It stays high until a word is accessed.
- R3: extReq is high combinationally when the block is armed, dmaEn is low and bufLevel meets the threshold. It is forced low in any cycle where dmaEn is high. dmaReq never rises while dmaEn is low.
- R4: dmaReq is low in the cycle after any wordAck. It is not raised again until burstDone has ended the current burst.
- R5: Outside a burst, burstLen equals min(clamped watermark, ceil(remaining block bytes / 4)). From the first wordAck until burstDone, it holds the value it had when the burst started.
- R6: The watermark is clamped to the range 1 to 128 words: 0 counts as 1, and any value above 128 counts as 128.
- R7: For a read (dirRead=1), the threshold in bytes is min(4 × clamped watermark, remaining block bytes). For a write, the threshold is 4 × burstLen bytes of free space. One byte below the threshold raises no request.
- R8: After the final word of a block that is not the last, the remaining byte count reloads to the armed block size. The next burstLen returns to the clamped watermark, or to the whole block when the block is shorter.
- R9: While the next word is the final word of a block with v = blockBytes mod 4 ≠ 0 valid bytes, stuffMask bit i (byte lane i) is set for every i ≥ v. Otherwise stuffMask is 0.
- R10: On the cycle after the final word of the last block, xferDone is high for exactly one cycle. After that, no request is raised, whatever bufLevel is, until arm is pulsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start pulse; loads block size and count (accepted while idle) |
| dmaEn | input | 1 | Internal DMA enable |
| dirRead | input | 1 | 1 = card-to-memory read, 0 = write |
| wmWords | input | WM_W (8) | Configured watermark in words |
| blkBytes | input | BYTE_W (12) | Block size in bytes |
| blkCount | input | CNT_W (16) | Number of blocks |
| bufLevel | input | LVL_W (12) | Buffered bytes (read) or free bytes (write) |
| wordAck | input | 1 | Engine accessed one buffer word |
| burstDone | input | 1 | Engine finished its burst |
| dmaReq | output | 1 | Internal DMA request |
| burstLen | output | 8 | Word count of the current/next burst |
| extReq | output | 1 | External DMA request, gated off by dmaEn |
| stuffMask | output | 4 | Discard mask for lanes of a block's final word |
| xferDone | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions assume the engine behaves properly:
- blkBytes and blkCount are at least one when arm is pulsed.
- arm is pulsed only while idle.
- wmWords and dirRead stay steady for the whole transfer.
- wordAck comes only while armed, and never together with burstDone.
- burstDone follows the burst's last word.

The stimulus plays this engine role. It issues exactly burstLen word strobes per request, and clears bufLevel before each burstDone. It steps the fill level from one byte under the computed threshold up to the threshold, across a sweep of block sizes, watermarks (including 0 and values above 128), counts and both directions.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  typedef struct packed {
    logic loadXfer;
    logic stepWord;
    logic nextBlock;
    logic finish;
    logic holdLen;
  } dpCtrl_t;
endpackage

// File: rtl/wbs_datapath.sv
module wbs_datapath
  import wbs_pkg::*;
#(
  parameter int BYTE_W    = 12,
  parameter int WM_W      = 8,
  parameter int LVL_W     = 12,
  parameter int MAX_BURST = 128,
  parameter int LEN_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [BYTE_W-1:0] blkBytes,
  input  logic [WM_W-1:0]   wmWords,
  input  logic              dirRead,
  input  logic [LVL_W-1:0]  bufLevel,
  output logic              thrMet,
  output logic              lastWord,
  output logic [LEN_W-1:0]  burstLen,
  output logic [3:0]        stuffMask
);
  localparam int CMP_W = BYTE_W + 2;

  logic [BYTE_W-1:0] remB, blkSizeQ;
  logic [LEN_W-1:0]  wmClamp, lenCalc, lenHold;
  logic [CMP_W-1:0]  remExt, remWords, wmBytes, thrBytes, lvlExt;

  always_comb begin
    if (wmWords == '0)                 wmClamp = LEN_W'(1);
    else if (int'(wmWords) > MAX_BURST) wmClamp = LEN_W'(MAX_BURST);
    else                               wmClamp = LEN_W'(wmWords);

    remExt   = CMP_W'(remB);
    remWords = (remExt + CMP_W'(3)) >> 2;
    lenCalc  = (remWords < CMP_W'(wmClamp)) ? LEN_W'(remWords) : wmClamp;
    wmBytes  = CMP_W'(wmClamp) << 2;

    if (dirRead) thrBytes = (remExt < wmBytes) ? remExt : wmBytes;
    else         thrBytes = CMP_W'(lenCalc) << 2;

    lvlExt    = CMP_W'(bufLevel);
    thrMet    = (remB != '0) && (lvlExt >= thrBytes);
    lastWord  = (remB != '0) && (remExt <= CMP_W'(4));
    stuffMask = ((remB != '0) && (remExt < CMP_W'(4))) ? 4'(4'hF << remB[1:0]) : 4'h0;
    burstLen  = ctrl.holdLen ? lenHold : lenCalc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remB     <= '0;
      blkSizeQ <= '0;
      lenHold  <= '0;
    end else begin
      if (ctrl.loadXfer) begin
        remB     <= blkBytes;
        blkSizeQ <= blkBytes;
      end else if (ctrl.finish) begin
        remB <= '0;
      end else if (ctrl.nextBlock) begin
        remB <= blkSizeQ;
      end else if (ctrl.stepWord) begin
        remB <= remB - BYTE_W'(4);
      end
      if (!ctrl.holdLen) lenHold <= lenCalc;
    end
  end

  // R5
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.holdLen && $past(ctrl.holdLen) |-> $stable(burstLen));
  // R6
  len_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remB != '0) && !ctrl.holdLen |-> (burstLen >= LEN_W'(1)) && (int'(burstLen) <= MAX_BURST));
  // R8
  blk_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.nextBlock) |-> remB == blkSizeQ);
endmodule

// File: rtl/wbs_control.sv
module wbs_control
  import wbs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             dmaEn,
  input  logic             wordAck,
  input  logic             burstDone,
  input  logic [CNT_W-1:0] blkCount,
  input  logic             thrMet,
  input  logic             lastWord,
  output dpCtrl_t          ctrl,
  output logic             dmaReq,
  output logic             extReq,
  output logic             xferDone
);
  logic             active, inBurst;
  logic [CNT_W-1:0] blksLeft;

  always_comb begin
    ctrl.loadXfer  = arm && !active;
    ctrl.stepWord  = wordAck && active;
    ctrl.nextBlock = ctrl.stepWord && lastWord && (blksLeft != CNT_W'(1));
    ctrl.finish    = ctrl.stepWord && lastWord && (blksLeft == CNT_W'(1));
    ctrl.holdLen   = inBurst;
    extReq         = active && !dmaEn && thrMet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      inBurst  <= 1'b0;
      dmaReq   <= 1'b0;
      xferDone <= 1'b0;
      blksLeft <= '0;
    end else begin
      if (ctrl.loadXfer)    active <= 1'b1;
      else if (ctrl.finish) active <= 1'b0;

      if (ctrl.loadXfer)       blksLeft <= blkCount;
      else if (ctrl.nextBlock) blksLeft <= blksLeft - CNT_W'(1);

      if (burstDone)          inBurst <= 1'b0;
      else if (ctrl.stepWord) inBurst <= 1'b1;

      if (wordAck || !dmaEn || !active)  dmaReq <= 1'b0;
      else if (!inBurst && thrMet)       dmaReq <= 1'b1;

      xferDone <= ctrl.finish;
    end
  end

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordAck |=> !dmaReq);
  // R3
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaEn |-> !extReq);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> !active && !dmaReq);
  // R2
  req_armed_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $past(dmaEn) && $past(thrMet));
endmodule

// File: rtl/wm_burst_sizer.sv
module wm_burst_sizer
  import wbs_pkg::*;
#(
  parameter int BYTE_W    = 12,
  parameter int CNT_W     = 16,
  parameter int WM_W      = 8,
  parameter int LVL_W     = 12,
  parameter int MAX_BURST = 128,
  localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              arm,
  input  logic              dmaEn,
  input  logic              dirRead,
  input  logic [WM_W-1:0]   wmWords,
  input  logic [BYTE_W-1:0] blkBytes,
  input  logic [CNT_W-1:0]  blkCount,
  input  logic [LVL_W-1:0]  bufLevel,
  input  logic              wordAck,
  input  logic              burstDone,
  output logic              dmaReq,
  output logic [LEN_W-1:0]  burstLen,
  output logic              extReq,
  output logic [3:0]        stuffMask,
  output logic              xferDone
);
  dpCtrl_t ctrl;
  logic    thrMet, lastWord;

  wbs_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .arm(arm), .dmaEn(dmaEn), .wordAck(wordAck),
    .burstDone(burstDone), .blkCount(blkCount), .thrMet(thrMet),
    .lastWord(lastWord), .ctrl(ctrl), .dmaReq(dmaReq), .extReq(extReq),
    .xferDone(xferDone)
  );

  wbs_datapath #(
    .BYTE_W(BYTE_W), .WM_W(WM_W), .LVL_W(LVL_W),
    .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .blkBytes(blkBytes),
    .wmWords(wmWords), .dirRead(dirRead), .bufLevel(bufLevel),
    .thrMet(thrMet), .lastWord(lastWord), .burstLen(burstLen),
    .stuffMask(stuffMask)
  );
endmodule

// File: tb/wm_burst_sizer_tb.sv
`timescale 1ns/1ps
module wm_burst_sizer_tb;
  logic        clk = 1'b0;
  logic        rstN, arm, dmaEn, dirRead, wordAck, burstDone;
  logic [7:0]  wmWords;
  logic [11:0] blkBytes;
  logic [15:0] blkCount;
  logic [11:0] bufLevel;
  logic        dmaReq, extReq, xferDone;
  logic [7:0]  burstLen;
  logic [3:0]  stuffMask;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wm_burst_sizer u_dut (
    .clk(clk), .rstN(rstN), .arm(arm), .dmaEn(dmaEn), .dirRead(dirRead),
    .wmWords(wmWords), .blkBytes(blkBytes), .blkCount(blkCount),
    .bufLevel(bufLevel), .wordAck(wordAck), .burstDone(burstDone),
    .dmaReq(dmaReq), .burstLen(burstLen), .extReq(extReq),
    .stuffMask(stuffMask), .xferDone(xferDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampWm(input int wm);
    if (wm == 0) return 1;
    if (wm > 128) return 128;
    return wm;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; arm = 1'b0; dmaEn = 1'b1; dirRead = 1'b1; wordAck = 1'b0;
    burstDone = 1'b0; wmWords = '0; blkBytes = '0; blkCount = '0; bufLevel = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runXfer(input int bytes, input int cnt, input int wm, input bit rd);
    int wmc;
    wmc = clampWm(wm);
    @(negedge clk);
    wmWords = 8'(wm); blkBytes = 12'(bytes); blkCount = 16'(cnt); dirRead = rd;
    dmaEn = 1'b1; bufLevel = '0; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int b = 0; b < cnt; b++) begin
      int rem;
      rem = bytes;
      while (rem > 0) begin
        int len, thr, words;
        words = (rem + 3) / 4;
        len = (words < wmc) ? words : wmc;
        thr = rd ? ((rem < wmc * 4) ? rem : wmc * 4) : len * 4;
        if (rem == bytes && b > 0)
          chk(int'(burstLen) == len, "R8 reload burstLen", int'(burstLen), len);
        else
          chk(int'(burstLen) == len, "R5/R6 burstLen", int'(burstLen), len);
        bufLevel = 12'(thr - 1);
        @(negedge clk);
        chk(dmaReq == 1'b0, "R7 below threshold", int'(dmaReq), 0);
        bufLevel = 12'(thr);
        @(negedge clk);
        chk(dmaReq == 1'b1, "R2 request raised", int'(dmaReq), 1);
        for (int w = 0; w < len; w++) begin
          int expMask;
          expMask = (rem < 4) ? ((4'hF << rem) & 4'hF) : 0;
          chk(int'(stuffMask) == expMask, "R9 stuffMask", int'(stuffMask), expMask);
          wordAck = 1'b1;
          @(negedge clk);
          wordAck = 1'b0;
          rem = (rem > 4) ? rem - 4 : 0;
          if (w == 0) begin
            chk(dmaReq == 1'b0, "R4 request dropped", int'(dmaReq), 0);
            chk(int'(burstLen) == len, "R5 burstLen held", int'(burstLen), len);
          end
          if (rem == 0 && b == cnt - 1)
            chk(xferDone == 1'b1, "R10 xferDone pulse", int'(xferDone), 1);
        end
        bufLevel = '0;
        burstDone = 1'b1;
        @(negedge clk);
        burstDone = 1'b0;
        if (!(rem == 0 && b == cnt - 1))
          chk(dmaReq == 1'b0, "R4 no request at zero level", int'(dmaReq), 0);
      end
    end
    chk(xferDone == 1'b0, "R10 single-cycle pulse", int'(xferDone), 0);
    chk(burstLen == 8'd0, "R10 idle burstLen", int'(burstLen), 0);
    bufLevel = 12'hFFF;
    @(negedge clk);
    chk(dmaReq == 1'b0, "R10 no request after done", int'(dmaReq), 0);
    bufLevel = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sizes[9] = '{1, 2, 3, 4, 5, 7, 8, 13, 31};
    int wms[5]   = '{0, 1, 2, 6, 200};
    doReset();
    // R1: reset state sampled after release, before any arm
    chk(dmaReq == 1'b0 && xferDone == 1'b0 && extReq == 1'b0, "R1 reset flags", 0, 0);
    chk(burstLen == 8'd0 && stuffMask == 4'd0, "R1 reset len/mask", int'(burstLen), 0);

    // R3: external request path and its gating
    @(negedge clk);
    dmaEn = 1'b0; wmWords = 8'd2; blkBytes = 12'd16; blkCount = 16'd1; dirRead = 1'b1;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    bufLevel = 12'd8;
    #0.5;
    chk(extReq == 1'b1, "R3 extReq with dmaEn low", int'(extReq), 1);
    @(negedge clk);
    chk(dmaReq == 1'b0, "R3 no internal request", int'(dmaReq), 0);
    dmaEn = 1'b1;
    #0.5;
    chk(extReq == 1'b0, "R3 extReq gated", int'(extReq), 0);
    doReset();

    // R6: large block with oversize watermark clamps to 128
    runXfer(600, 1, 255, 1'b1);
    runXfer(31, 2, 6, 1'b1);
    runXfer(31, 2, 6, 1'b0);

    foreach (sizes[i])
      foreach (wms[j])
        for (int c = 1; c <= 2; c++)
          for (int d = 0; d < 2; d++)
            runXfer(sizes[i], c, wms[j], d[0]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule